// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address after a TLB miss. It walks a two-level page table held in physical memory. A walk request carries the virtual address. The walker takes the current table root from its root input and issues two dependent reads on a simple memory port. Both reads use physical addresses, so no translation is applied to them.

The first read fetches the first-level entry. That entry names the page holding the second-level table, and the second read fetches the leaf entry from that page. The walker returns a one-cycle result carrying either a physical page number with its permission bits, ready for a TLB refill, or a page-fault flag. An entry whose valid bit is clear means the page is absent or not resident, and it ends the walk as a fault at either level.

The walker handles one walk at a time. It reports busy from acceptance until the result cycle.

Top module: `ptw2_top`

## Requirements
- R1: After reset, busy_o, res_valid_o and mem_req_o are all low.
- R2: The first read targets root_base_i (captured when the request is accepted) plus vaddr[31:22] times 4.
- R3: The second read targets {first-level entry[31:12], 12'h000} plus vaddr[21:12] times 4.
- R4: Once mem_req_o rises, it stays high and mem_addr_o stays unchanged until a cycle in which mem_ready_i is high.
- R5: A first-level entry with bit 0 clear ends the walk with res_fault_o high, and no second read is issued.
- R6: A second-level entry with bit 0 clear ends the walk with res_fault_o high. Every faulting result has res_ppn_o and res_perm_o at zero.
- R7: A successful walk returns res_fault_o low, res_ppn_o equal to leaf entry bits 31..12, and res_perm_o equal to leaf entry bits 3..1.
- R8: res_valid_o is high for exactly one cycle per walk. In the next cycle busy_o is low.
- R9: A request is accepted only while busy_o is low. busy_o is high from the cycle after acceptance through the result cycle. Requests presented while busy have no effect on the reads or on the result.
- R10: No new read is requested while a previous read has been accepted but its data has not yet returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| root_base_i | input | 32 | Physical base of the first-level table |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Physical address of the entry being read |
| mem_ready_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data (page table entry) |
| res_valid_o | output | 1 | Result pulse |
| res_fault_o | output | 1 | Walk ended in page fault |
| res_ppn_o | output | 20 | Physical page number |
| res_perm_o | output | 3 | Permissions {x,w,r} |

## Verification
The checker watches four things on every cycle:
- the two read addresses, derived from the captured root and address;
- the request hold under backpressure;
- the single outstanding read;
- the shape of the result pulse.

It also checks that a fault carries a zeroed payload and that a successful result matches the leaf entry it read. Only the bench scenarios can show some other behaviour:
- that a first-level fault really suppresses the second read;
- that requests made while busy leave no trace;
- that index extremes wrap into the right table slots;
- that results stay correct under memory stalls and read latency.

// File: rtl/ptw2_pkg.sv
package ptw2_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  localparam int unsigned LEVELS    = 2;
  localparam int unsigned VALID_BIT = 0;
  localparam int unsigned PERM_LSB  = 1;
endpackage

// File: rtl/ptw2_addr_gen.sv
module ptw2_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned PAD_W = ADDR_W - IDX_W - 2;

  // entries are 4 bytes wide
  assign addr_o = base_i + {{PAD_W{1'b0}}, idx_i, 2'b00};
endmodule

// File: rtl/ptw2_pte_decode.sv
module ptw2_pte_decode #(
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PERM_W = 3
) (
  input  logic [PTE_W-1:0]       pte_i,
  output logic                   ok_o,
  output logic [PTE_W-OFF_W-1:0] ppn_o,
  output logic [PERM_W-1:0]      perm_o
);
  import ptw2_pkg::*;

  assign ok_o   = pte_i[VALID_BIT];
  assign ppn_o  = pte_i[PTE_W-1:OFF_W];
  assign perm_o = pte_i[PERM_LSB +: PERM_W];
endmodule

// File: rtl/ptw2_ctrl.sv
module ptw2_ctrl
  import ptw2_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        mem_ready_i,
  input  logic        mem_rvalid_i,
  input  logic        pte_ok_i,
  output walk_state_e state_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i)      state_d = ST_L1_REQ;
      ST_L1_REQ:  if (mem_ready_i)  state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rvalid_i) state_d = pte_ok_i ? ST_L2_REQ : ST_FAULT;
      ST_L2_REQ:  if (mem_ready_i)  state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rvalid_i) state_d = pte_ok_i ? ST_DONE : ST_FAULT;
      ST_DONE,
      ST_FAULT:                     state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ptw2_top.sv
module ptw2_top
  import ptw2_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned PERM_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [VA_W-1:0]        req_vaddr_i,
  input  logic [PTE_W-1:0]       root_base_i,
  output logic                   busy_o,
  output logic                   mem_req_o,
  output logic [PTE_W-1:0]       mem_addr_o,
  input  logic                   mem_ready_i,
  input  logic                   mem_rvalid_i,
  input  logic [PTE_W-1:0]       mem_rdata_i,
  output logic                   res_valid_o,
  output logic                   res_fault_o,
  output logic [PTE_W-OFF_W-1:0] res_ppn_o,
  output logic [PERM_W-1:0]      res_perm_o
);
  localparam int unsigned PPN_W = PTE_W - OFF_W;

  walk_state_e state;
  logic        start;
  logic        pte_ok;
  logic [PPN_W-1:0]  pte_ppn;
  logic [PERM_W-1:0] pte_perm;

  logic [VA_W-1:0]   va_q;
  logic [PTE_W-1:0]  root_q;
  logic [PPN_W-1:0]  tbl_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [PERM_W-1:0] perm_q;

  logic [PTE_W-1:0] lvl_base [LEVELS];
  logic [IDX_W-1:0] lvl_idx  [LEVELS];
  logic [PTE_W-1:0] lvl_addr [LEVELS];

  assign start = (state == ST_IDLE) && req_valid_i;

  ptw2_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .mem_ready_i  (mem_ready_i),
    .mem_rvalid_i (mem_rvalid_i),
    .pte_ok_i     (pte_ok),
    .state_o      (state)
  );

  ptw2_pte_decode #(
    .PTE_W  (PTE_W),
    .OFF_W  (OFF_W),
    .PERM_W (PERM_W)
  ) u_dec (
    .pte_i  (mem_rdata_i),
    .ok_o   (pte_ok),
    .ppn_o  (pte_ppn),
    .perm_o (pte_perm)
  );

  assign lvl_base[0] = root_q;
  assign lvl_base[1] = {tbl_q, {OFF_W{1'b0}}};

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    assign lvl_idx[l] = va_q[VA_W-1-l*IDX_W -: IDX_W];
    ptw2_addr_gen #(
      .ADDR_W (PTE_W),
      .IDX_W  (IDX_W)
    ) u_agen (
      .base_i (lvl_base[l]),
      .idx_i  (lvl_idx[l]),
      .addr_o (lvl_addr[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q   <= '0;
      root_q <= '0;
      tbl_q  <= '0;
      ppn_q  <= '0;
      perm_q <= '0;
    end else begin
      if (start) begin
        va_q   <= req_vaddr_i;
        root_q <= root_base_i;
      end
      if (state == ST_L1_WAIT && mem_rvalid_i) tbl_q <= pte_ppn;
      if (state == ST_L2_WAIT && mem_rvalid_i) begin
        ppn_q  <= pte_ppn;
        perm_q <= pte_perm;
      end
    end
  end

  assign busy_o      = (state != ST_IDLE);
  assign mem_req_o   = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign mem_addr_o  = (state == ST_L2_REQ) ? lvl_addr[1] : lvl_addr[0];
  assign res_valid_o = (state == ST_DONE) || (state == ST_FAULT);
  assign res_fault_o = (state == ST_FAULT);
  assign res_ppn_o   = (state == ST_DONE) ? ppn_q  : '0;
  assign res_perm_o  = (state == ST_DONE) ? perm_q : '0;
endmodule

// File: rtl/ptw2_checker.sv
module ptw2_checker #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned PERM_W = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic [VA_W-1:0]        req_vaddr_i,
  input logic [PTE_W-1:0]       root_base_i,
  input logic                   busy_o,
  input logic                   mem_req_o,
  input logic [PTE_W-1:0]       mem_addr_o,
  input logic                   mem_ready_i,
  input logic                   mem_rvalid_i,
  input logic [PTE_W-1:0]       mem_rdata_i,
  input logic                   res_valid_o,
  input logic                   res_fault_o,
  input logic [PTE_W-OFF_W-1:0] res_ppn_o,
  input logic [PERM_W-1:0]      res_perm_o
);
  localparam int unsigned PAD_W = PTE_W - IDX_W - 2;

  logic [VA_W-1:0]  va_c;
  logic [PTE_W-1:0] root_c, l1_c, l2_c;
  logic [1:0]       hs_cnt, rd_cnt;
  logic             outstanding;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_c <= '0; root_c <= '0; l1_c <= '0; l2_c <= '0;
      hs_cnt <= '0; rd_cnt <= '0; outstanding <= 1'b0;
    end else begin
      if (!busy_o && req_valid_i) begin
        va_c <= req_vaddr_i; root_c <= root_base_i;
        hs_cnt <= '0; rd_cnt <= '0;
      end else begin
        if (mem_req_o && mem_ready_i) hs_cnt <= hs_cnt + 2'd1;
        if (mem_rvalid_i && outstanding) begin
          rd_cnt <= rd_cnt + 2'd1;
          if (rd_cnt == 2'd0) l1_c <= mem_rdata_i;
          else                l2_c <= mem_rdata_i;
        end
      end
      if (mem_req_o && mem_ready_i) outstanding <= 1'b1;
      else if (mem_rvalid_i)        outstanding <= 1'b0;
    end
  end

  a_r2_l1_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && hs_cnt == 2'd0 |->
      mem_addr_o == root_c + {{PAD_W{1'b0}}, va_c[VA_W-1 -: IDX_W], 2'b00});

  a_r3_l2_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && hs_cnt == 2'd1 |->
      mem_addr_o == {l1_c[PTE_W-1:OFF_W], {OFF_W{1'b0}}}
                    + {{PAD_W{1'b0}}, va_c[VA_W-1-IDX_W -: IDX_W], 2'b00});

  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  a_r5_l1_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding && mem_rvalid_i && rd_cnt == 2'd0 && !mem_rdata_i[0] |=>
      res_valid_o && res_fault_o);

  a_r6_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_fault_o |-> res_ppn_o == '0 && res_perm_o == '0);

  a_r7_hit_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_fault_o |->
      res_ppn_o == l2_c[PTE_W-1:OFF_W] && res_perm_o == l2_c[1 +: PERM_W]);

  a_r8_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o && !busy_o);

  a_r9_busy_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> busy_o);

  a_r10_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding |-> !mem_req_o);
endmodule

bind ptw2_top ptw2_checker #(
  .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PTE_W(PTE_W), .PERM_W(PERM_W)
) u_chk (.*);

// File: tb/ptw2_top_tb_top.sv
`timescale 1ns/1ps
module ptw2_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] root_base = 32'h0001_0000;
  logic        busy, mem_req, mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        res_valid, res_fault;
  logic [19:0] res_ppn;
  logic [2:0]  res_perm;

  int total = 0, bad = 0;
  int stall = 0, lat = 0;
  int rd_n = 0;
  logic [31:0] rd_log [4];
  logic [31:0] mem_m [logic [31:0]];

  always #2 clk = ~clk;

  ptw2_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .root_base_i(root_base),
    .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ready_i(mem_ready), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .res_valid_o(res_valid), .res_fault_o(res_fault),
    .res_ppn_o(res_ppn), .res_perm_o(res_perm)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      mem_ready = 1'b0; mem_rvalid = 1'b0;
      if (mem_req && rst_n) begin
        logic [31:0] a;
        a = mem_addr;
        for (int i = 0; i < stall; i++) begin
          @(negedge clk);
          chk(mem_req === 1'b1, "R4", "req dropped in stall", {31'd0, mem_req}, 32'd1);
          chk(mem_addr === a, "R4", "addr moved in stall", mem_addr, a);
        end
        mem_ready = 1'b1;
        if (rd_n < 4) rd_log[rd_n] = a;
        rd_n++;
        @(negedge clk);
        mem_ready = 1'b0;
        chk(mem_req === 1'b0, "R10", "req during outstanding read", {31'd0, mem_req}, 32'd0);
        for (int i = 0; i < lat; i++) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata = mem_m.exists(a) ? mem_m[a] : 32'd0;
      end
    end
  end

  function automatic logic [31:0] l1_addr(input logic [31:0] va);
    return root_base + {20'd0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] l2_addr(input logic [31:0] va, input logic [19:0] tbl);
    return {tbl, 12'h000} + {20'd0, va[21:12], 2'b00};
  endfunction

  task automatic set_map(input logic [31:0] va, input logic [19:0] tbl, input bit l1v,
                         input logic [19:0] ppn, input logic [2:0] perm, input bit l2v);
    mem_m[l1_addr(va)] = {tbl, 11'd0, l1v};
    mem_m[l2_addr(va, tbl)] = {ppn, 8'd0, perm, l2v};
  endtask

  task automatic do_walk(input string rq, input logic [31:0] va, input bit exp_fault,
                         input logic [19:0] exp_ppn, input logic [2:0] exp_perm,
                         input int exp_n, input logic [31:0] a0, input logic [31:0] a1,
                         input bit inject, input logic [31:0] va2);
    int n;
    rd_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9", "busy after accept", {31'd0, busy}, 32'd1);
    if (inject) begin
      req_valid = 1'b1; req_vaddr = va2;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (res_valid !== 1'b1 && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(res_valid === 1'b1, rq, "result seen", {31'd0, res_valid}, 32'd1);
    chk(res_fault === exp_fault, rq, "fault flag", {31'd0, res_fault}, {31'd0, exp_fault});
    chk(res_ppn === exp_ppn, rq, "ppn", {12'd0, res_ppn}, {12'd0, exp_ppn});
    chk(res_perm === exp_perm, rq, "perm", {29'd0, res_perm}, {29'd0, exp_perm});
    chk(busy === 1'b1, "R9", "busy in result cycle", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk(res_valid === 1'b0, "R8", "pulse width", {31'd0, res_valid}, 32'd0);
    chk(busy === 1'b0, "R8", "busy after result", {31'd0, busy}, 32'd0);
    chk(rd_n == exp_n, rq, "read count", rd_n, exp_n);
    if (rd_n >= 1) chk(rd_log[0] === a0, "R2", "first read addr", rd_log[0], a0);
    if (rd_n >= 2 && exp_n >= 2) chk(rd_log[1] === a1, "R3", "second read addr", rd_log[1], a1);
  endtask

  task automatic t_reset;
    chk(busy === 1'b0, "R1", "busy at reset", {31'd0, busy}, 32'd0);
    chk(res_valid === 1'b0, "R1", "res_valid at reset", {31'd0, res_valid}, 32'd0);
    chk(mem_req === 1'b0, "R1", "mem_req at reset", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_hit;
    logic [31:0] va = 32'h0040_3123;
    stall = 0; lat = 0;
    set_map(va, 20'h00200, 1'b1, 20'hABCDE, 3'b101, 1'b1);
    do_walk("R7", va, 1'b0, 20'hABCDE, 3'b101, 2, l1_addr(va), l2_addr(va, 20'h00200), 1'b0, '0);
  endtask

  task automatic t_l1_fault;
    logic [31:0] va = 32'h0080_0000;
    stall = 0; lat = 1;
    set_map(va, 20'h00700, 1'b0, 20'h11111, 3'b111, 1'b1);
    do_walk("R5", va, 1'b1, 20'h0, 3'b0, 1, l1_addr(va), '0, 1'b0, '0);
  endtask

  task automatic t_l2_fault;
    logic [31:0] va = 32'h00C0_5000;
    stall = 1; lat = 0;
    set_map(va, 20'h00300, 1'b1, 20'h77777, 3'b111, 1'b0);
    do_walk("R6", va, 1'b1, 20'h0, 3'b0, 2, l1_addr(va), l2_addr(va, 20'h00300), 1'b0, '0);
  endtask

  task automatic t_stall;
    logic [31:0] va = 32'h0101_0000;
    stall = 3; lat = 2;
    set_map(va, 20'h00400, 1'b1, 20'h12345, 3'b011, 1'b1);
    do_walk("R4", va, 1'b0, 20'h12345, 3'b011, 2, l1_addr(va), l2_addr(va, 20'h00400), 1'b0, '0);
  endtask

  task automatic t_edges;
    logic [31:0] va = 32'hFFFF_FFFF;
    logic [31:0] vz = 32'h0000_0ABC;
    stall = 0; lat = 0;
    set_map(va, 20'hFFFFF, 1'b1, 20'h00001, 3'b111, 1'b1);
    do_walk("R3", va, 1'b0, 20'h00001, 3'b111, 2, l1_addr(va), l2_addr(va, 20'hFFFFF), 1'b0, '0);
    set_map(vz, 20'h00500, 1'b1, 20'hFEDCB, 3'b001, 1'b1);
    do_walk("R2", vz, 1'b0, 20'hFEDCB, 3'b001, 2, l1_addr(vz), l2_addr(vz, 20'h00500), 1'b0, '0);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] va = 32'h0140_2000;
    stall = 3; lat = 1;
    set_map(va, 20'h00600, 1'b1, 20'h55555, 3'b110, 1'b1);
    do_walk("R9", va, 1'b0, 20'h55555, 3'b110, 2, l1_addr(va), l2_addr(va, 20'h00600),
            1'b1, 32'h0180_0000);
    @(negedge clk);
    chk(busy === 1'b0, "R9", "no walk started by ignored request", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit();
    t_l1_fault();
    t_l2_fault();
    t_stall();
    t_edges();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule